// File: doc/BRIEF.md
# Metering Element Product Calculator

This block forms the per-sample power products that an energy meter sums into watt-hours. For every sample it receives the signed voltage and current of three phases and a 3-bit wiring code. The code tells it how many measuring elements the meter has, which voltage each element uses and which current it multiplies with. The current is either one phase current or half the difference of two phase currents. That covers single-phase, delta and wye installations.

The samples, the strobe and the wiring code are all captured on the same clock edge. Three signed products come out a fixed two clocks later, each with a valid flag of its own. An element that the chosen wiring does not use outputs zero and keeps its flag low. Between results the products keep their values. The block does no accumulation, gain correction, reactive phase shift or input multiplexing.

Top module: `meter_elem_calc`

## Requirements
- R1: After reset all three products are zero and all three valid flags are low.
- R2: Code 0 gives element 0 = VA·IA and element 1 = VA·IB. Element 2 is unused.
- R3: Code 1 gives element 0 = VA·(IA−IB)/2. Elements 1 and 2 are unused.
- R4: Code 2 gives element 0 = VA·IA and element 1 = VB·IB. Element 2 is unused.
- R5: Code 3 gives element 0 = VA·(IA−IB)/2 and element 2 = VC·IC. Element 1 is unused.
- R6: Code 4 gives element 0 = VA·(IA−IB)/2 and element 1 = VB·(IC−IB)/2. Element 2 is unused.
- R7: Code 5 gives element 0 = VA·IA, element 1 = VB·IB and element 2 = VC·IC.
- R8: Codes 6 and 7 drive all three products to zero and keep all three valid flags low.
- R9: An element unused by the sampled code outputs zero and its valid flag stays low.
- R10: Results and their flags appear two clock edges after the edge that samples the strobe, and the flags are high for one cycle only. The code and samples are taken at the strobe edge, so changes made after that edge do not affect the result.
- R11: A current difference is formed one bit wider than the inputs, so it cannot overflow. The halving is an arithmetic right shift by one of the full-precision product, which rounds toward minus infinity. Products are 2·SW+1 bits, signed two's complement.
- R12: When no result is due, all three products keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe; captures samples and code |
| eq_code | input | 3 | Wiring code, 0 to 5 valid |
| volt_a | input | SW | Phase A voltage, signed |
| volt_b | input | SW | Phase B voltage, signed |
| volt_c | input | SW | Phase C voltage, signed |
| curr_a | input | SW | Phase A current, signed |
| curr_b | input | SW | Phase B current, signed |
| curr_c | input | SW | Phase C current, signed |
| elem0_p | output | 2*SW+1 | Element 0 product, signed |
| elem1_p | output | 2*SW+1 | Element 1 product, signed |
| elem2_p | output | 2*SW+1 | Element 2 product, signed |
| elem0_vld | output | 1 | Element 0 result valid |
| elem1_vld | output | 1 | Element 1 result valid |
| elem2_vld | output | 1 | Element 2 result valid |

## Verification
Every product and flag is due on the second rising edge after the edge that sees the strobe. There is one register for the selected operands and one for the products. The bench raises the strobe at a falling edge. It checks that no flag is high one falling edge later, reads all results at the falling edge after that, and checks at the next falling edge that the flags have dropped while the products held. Right after each strobe the code and samples are overwritten with other values, so any late sampling shows up as a wrong product.

// File: rtl/meq_pkg.sv
package meq_pkg;

    localparam int NUM_ELEM = 3;
    localparam logic [2:0] EQ_LAST = 3'd5;

    typedef enum logic [1:0] {
        VS_A = 2'd0,
        VS_B = 2'd1,
        VS_C = 2'd2
    } vsel_e;

    typedef enum logic [2:0] {
        IS_A  = 3'd0,
        IS_B  = 3'd1,
        IS_C  = 3'd2,
        IS_AB = 3'd3,
        IS_CB = 3'd4
    } isel_e;

    typedef struct packed {
        logic  en;
        vsel_e vsel;
        isel_e isel;
    } elem_cfg_t;

endpackage

// File: rtl/meq_decode.sv
module meq_decode
    import meq_pkg::*;
(
    input  logic [2:0]                 code,
    output elem_cfg_t [NUM_ELEM-1:0]   cfg
);

    localparam elem_cfg_t OFF = '{en: 1'b0, vsel: VS_A, isel: IS_A};

    always_comb begin
        cfg = {NUM_ELEM{OFF}};
        unique case (code)
            3'd0: begin
                cfg[0] = '{en: 1'b1, vsel: VS_A, isel: IS_A};
                cfg[1] = '{en: 1'b1, vsel: VS_A, isel: IS_B};
            end
            3'd1: begin
                cfg[0] = '{en: 1'b1, vsel: VS_A, isel: IS_AB};
            end
            3'd2: begin
                cfg[0] = '{en: 1'b1, vsel: VS_A, isel: IS_A};
                cfg[1] = '{en: 1'b1, vsel: VS_B, isel: IS_B};
            end
            3'd3: begin
                cfg[0] = '{en: 1'b1, vsel: VS_A, isel: IS_AB};
                cfg[2] = '{en: 1'b1, vsel: VS_C, isel: IS_C};
            end
            3'd4: begin
                cfg[0] = '{en: 1'b1, vsel: VS_A, isel: IS_AB};
                cfg[1] = '{en: 1'b1, vsel: VS_B, isel: IS_CB};
            end
            3'd5: begin
                cfg[0] = '{en: 1'b1, vsel: VS_A, isel: IS_A};
                cfg[1] = '{en: 1'b1, vsel: VS_B, isel: IS_B};
                cfg[2] = '{en: 1'b1, vsel: VS_C, isel: IS_C};
            end
            default: cfg = {NUM_ELEM{OFF}};
        endcase
    end

endmodule

// File: rtl/meq_operand_stage.sv
module meq_operand_stage
    import meq_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  elem_cfg_t [NUM_ELEM-1:0]   cfg,
    input  logic [SW-1:0]              volt_a,
    input  logic [SW-1:0]              volt_b,
    input  logic [SW-1:0]              volt_c,
    input  logic [SW-1:0]              curr_a,
    input  logic [SW-1:0]              curr_b,
    input  logic [SW-1:0]              curr_c,
    output logic                       op_vld,
    output logic [NUM_ELEM-1:0]        op_en,
    output logic [NUM_ELEM-1:0]        op_half,
    output logic [NUM_ELEM*SW-1:0]     op_volt,
    output logic [NUM_ELEM*(SW+1)-1:0] op_curr
);

    localparam int IW = SW + 1;

    typedef struct packed {
        logic                      vld;
        logic [NUM_ELEM-1:0]       en;
        logic [NUM_ELEM-1:0]       half;
        logic [NUM_ELEM*SW-1:0]    volt;
        logic [NUM_ELEM*IW-1:0]    curr;
    } opst_t;

    opst_t st_d, st_q;

    // Sign-extended phase currents and the two wide differences.
    logic [IW-1:0] ia_x, ib_x, ic_x, dab, dcb;

    always_comb begin
        ia_x = {curr_a[SW-1], curr_a};
        ib_x = {curr_b[SW-1], curr_b};
        ic_x = {curr_c[SW-1], curr_c};
        dab  = ia_x - ib_x;
        dcb  = ic_x - ib_x;
    end

    logic [NUM_ELEM*SW-1:0] vsel_w;
    logic [NUM_ELEM*IW-1:0] isel_w;
    logic [NUM_ELEM-1:0]    half_w;

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_sel
        always_comb begin
            unique case (cfg[e].vsel)
                VS_B:    vsel_w[e*SW +: SW] = volt_b;
                VS_C:    vsel_w[e*SW +: SW] = volt_c;
                default: vsel_w[e*SW +: SW] = volt_a;
            endcase
            half_w[e] = 1'b0;
            unique case (cfg[e].isel)
                IS_B:    isel_w[e*IW +: IW] = ib_x;
                IS_C:    isel_w[e*IW +: IW] = ic_x;
                IS_AB: begin
                    isel_w[e*IW +: IW] = dab;
                    half_w[e]          = 1'b1;
                end
                IS_CB: begin
                    isel_w[e*IW +: IW] = dcb;
                    half_w[e]          = 1'b1;
                end
                default: isel_w[e*IW +: IW] = ia_x;
            endcase
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = smp_valid;
        if (smp_valid) begin
            for (int e = 0; e < NUM_ELEM; e++) begin
                st_d.en[e] = cfg[e].en;
            end
            st_d.half = half_w;
            st_d.volt = vsel_w;
            st_d.curr = isel_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_vld  = st_q.vld;
    assign op_en   = st_q.en;
    assign op_half = st_q.half;
    assign op_volt = st_q.volt;
    assign op_curr = st_q.curr;

endmodule

// File: rtl/meq_product_stage.sv
module meq_product_stage
    import meq_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       op_vld,
    input  logic [NUM_ELEM-1:0]        op_en,
    input  logic [NUM_ELEM-1:0]        op_half,
    input  logic [NUM_ELEM*SW-1:0]     op_volt,
    input  logic [NUM_ELEM*(SW+1)-1:0] op_curr,
    output logic [NUM_ELEM*(2*SW+1)-1:0] prod,
    output logic [NUM_ELEM-1:0]        prod_vld
);

    localparam int IW = SW + 1;
    localparam int PW = 2 * SW + 1;

    typedef struct packed {
        logic [NUM_ELEM-1:0]    vld;
        logic [NUM_ELEM*PW-1:0] p;
    } pst_t;

    pst_t st_d, st_q;

    logic [NUM_ELEM*PW-1:0] res_w;

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_mul
        logic signed [SW-1:0] v_s;
        logic signed [IW-1:0] i_s;
        logic signed [PW-1:0] full;
        always_comb begin
            v_s  = $signed(op_volt[e*SW +: SW]);
            i_s  = $signed(op_curr[e*IW +: IW]);
            full = PW'(v_s) * PW'(i_s);
            if (!op_en[e]) begin
                res_w[e*PW +: PW] = '0;
            end else if (op_half[e]) begin
                res_w[e*PW +: PW] = full >>> 1;
            end else begin
                res_w[e*PW +: PW] = full;
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = '0;
        if (op_vld) begin
            st_d.vld = op_en;
            st_d.p   = res_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prod     = st_q.p;
    assign prod_vld = st_q.vld;

endmodule

// File: rtl/meter_elem_calc.sv
module meter_elem_calc
    import meq_pkg::*;
#(
    parameter int SW = 16,
    localparam int PW = 2 * SW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [2:0]    eq_code,
    input  logic [SW-1:0] volt_a,
    input  logic [SW-1:0] volt_b,
    input  logic [SW-1:0] volt_c,
    input  logic [SW-1:0] curr_a,
    input  logic [SW-1:0] curr_b,
    input  logic [SW-1:0] curr_c,
    output logic [PW-1:0] elem0_p,
    output logic [PW-1:0] elem1_p,
    output logic [PW-1:0] elem2_p,
    output logic          elem0_vld,
    output logic          elem1_vld,
    output logic          elem2_vld
);

    elem_cfg_t [NUM_ELEM-1:0]   cfg;
    logic                       op_vld;
    logic [NUM_ELEM-1:0]        op_en;
    logic [NUM_ELEM-1:0]        op_half;
    logic [NUM_ELEM*SW-1:0]     op_volt;
    logic [NUM_ELEM*(SW+1)-1:0] op_curr;
    logic [NUM_ELEM*PW-1:0]     prod;
    logic [NUM_ELEM-1:0]        prod_vld;

    meq_decode u_decode (
        .code (eq_code),
        .cfg  (cfg)
    );

    meq_operand_stage #(.SW(SW)) u_opnd (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .cfg       (cfg),
        .volt_a    (volt_a),
        .volt_b    (volt_b),
        .volt_c    (volt_c),
        .curr_a    (curr_a),
        .curr_b    (curr_b),
        .curr_c    (curr_c),
        .op_vld    (op_vld),
        .op_en     (op_en),
        .op_half   (op_half),
        .op_volt   (op_volt),
        .op_curr   (op_curr)
    );

    meq_product_stage #(.SW(SW)) u_prod (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_vld   (op_vld),
        .op_en    (op_en),
        .op_half  (op_half),
        .op_volt  (op_volt),
        .op_curr  (op_curr),
        .prod     (prod),
        .prod_vld (prod_vld)
    );

    assign elem0_p   = prod[0*PW +: PW];
    assign elem1_p   = prod[1*PW +: PW];
    assign elem2_p   = prod[2*PW +: PW];
    assign elem0_vld = prod_vld[0];
    assign elem1_vld = prod_vld[1];
    assign elem2_vld = prod_vld[2];

endmodule

// File: rtl/meq_checker.sv
module meq_checker #(
    parameter int PW = 33
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic [2:0]    eq_code,
    input logic [PW-1:0] elem0_p,
    input logic [PW-1:0] elem1_p,
    input logic [PW-1:0] elem2_p,
    input logic          elem0_vld,
    input logic          elem1_vld,
    input logic          elem2_vld
);

    logic any_vld;
    assign any_vld = elem0_vld | elem1_vld | elem2_vld;

    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        any_vld |-> $past(smp_valid, 2));

    a_r8_invalid_code: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && eq_code > 3'd5) |=> ##1 !any_vld);

    a_r7_three_elements: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && eq_code == 3'd5) |=> ##1 (elem0_vld && elem1_vld && elem2_vld));

    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        any_vld |-> ((elem0_vld || elem0_p == '0) &&
                     (elem1_vld || elem1_p == '0) &&
                     (elem2_vld || elem2_p == '0)));

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_valid, 2) |-> ($stable(elem0_p) && $stable(elem1_p) && $stable(elem2_p)));

endmodule

bind meter_elem_calc meq_checker #(.PW(PW)) u_meq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .eq_code   (eq_code),
    .elem0_p   (elem0_p),
    .elem1_p   (elem1_p),
    .elem2_p   (elem2_p),
    .elem0_vld (elem0_vld),
    .elem1_vld (elem1_vld),
    .elem2_vld (elem2_vld)
);

// File: tb/meter_elem_calc_bench.sv
module meter_elem_calc_bench;

    localparam int SW      = 16;
    localparam int PW      = 2 * SW + 1;
    localparam int CLK_PER = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [2:0]    eq_code = '0;
    logic [SW-1:0] volt_a = '0, volt_b = '0, volt_c = '0;
    logic [SW-1:0] curr_a = '0, curr_b = '0, curr_c = '0;
    logic signed [PW-1:0] elem0_p, elem1_p, elem2_p;
    logic          elem0_vld, elem1_vld, elem2_vld;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PER/2) clk = ~clk;

    meter_elem_calc #(.SW(SW)) u_meter_elem_calc (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .eq_code   (eq_code),
        .volt_a    (volt_a),
        .volt_b    (volt_b),
        .volt_c    (volt_c),
        .curr_a    (curr_a),
        .curr_b    (curr_b),
        .curr_c    (curr_c),
        .elem0_p   (elem0_p),
        .elem1_p   (elem1_p),
        .elem2_p   (elem2_p),
        .elem0_vld (elem0_vld),
        .elem1_vld (elem1_vld),
        .elem2_vld (elem2_vld)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string req_of(input int code);
        case (code)
            0: return "R2";
            1: return "R3 R11";
            2: return "R4";
            3: return "R5 R11";
            4: return "R6 R11";
            5: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Expected product and flag per requirement R2..R9, R11.
    function automatic void model(input int code, input int e,
                                  input longint va, vb, vc, ia, ib, ic,
                                  output longint val, output bit en);
        longint hab, hcb;
        hab = (va * (ia - ib)) >>> 1;
        hcb = (vb * (ic - ib)) >>> 1;
        val = 0;
        en  = 1'b0;
        case (code)
            0: if (e == 0) begin val = va * ia; en = 1; end
               else if (e == 1) begin val = va * ib; en = 1; end
            1: if (e == 0) begin val = hab; en = 1; end
            2: if (e == 0) begin val = va * ia; en = 1; end
               else if (e == 1) begin val = vb * ib; en = 1; end
            3: if (e == 0) begin val = hab; en = 1; end
               else if (e == 2) begin val = vc * ic; en = 1; end
            4: if (e == 0) begin val = hab; en = 1; end
               else if (e == 1) begin val = hcb; en = 1; end
            5: if (e == 0) begin val = va * ia; en = 1; end
               else if (e == 1) begin val = vb * ib; en = 1; end
               else begin val = vc * ic; en = 1; end
            default: ;
        endcase
    endfunction

    function automatic longint get_p(input int e);
        case (e)
            0: return longint'(elem0_p);
            1: return longint'(elem1_p);
            default: return longint'(elem2_p);
        endcase
    endfunction

    function automatic bit get_v(input int e);
        case (e)
            0: return elem0_vld;
            1: return elem1_vld;
            default: return elem2_vld;
        endcase
    endfunction

    // One strobe, then scramble inputs (R10), check at the due cycle and after.
    task automatic run_one(input int code, input int va, vb, vc, ia, ib, ic);
        longint ev;
        bit     ee;
        longint held [3];
        @(negedge clk);
        eq_code = 3'(code);
        volt_a = SW'(va); volt_b = SW'(vb); volt_c = SW'(vc);
        curr_a = SW'(ia); curr_b = SW'(ib); curr_c = SW'(ic);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        eq_code = 3'd5;
        volt_a = ~volt_a; volt_b = volt_b + 16'd7; volt_c = ~volt_c;
        curr_a = curr_a + 16'd3; curr_b = ~curr_b; curr_c = curr_c - 16'd5;
        chk(!(elem0_vld | elem1_vld | elem2_vld), "R10 early flag",
            longint'({elem2_vld, elem1_vld, elem0_vld}), 0);
        @(negedge clk);
        for (int e = 0; e < 3; e++) begin
            model(code, e, longint'(signed'(SW'(va))), longint'(signed'(SW'(vb))),
                  longint'(signed'(SW'(vc))), longint'(signed'(SW'(ia))),
                  longint'(signed'(SW'(ib))), longint'(signed'(SW'(ic))), ev, ee);
            chk(get_p(e) == ev, ee ? req_of(code) : "R9 product", get_p(e), ev);
            chk(get_v(e) == ee, ee ? "R10 flag" : "R9 flag", longint'(get_v(e)), longint'(ee));
            held[e] = get_p(e);
        end
        @(negedge clk);
        for (int e = 0; e < 3; e++) begin
            chk(get_v(e) == 1'b0, "R10 single-cycle flag", longint'(get_v(e)), 0);
            chk(get_p(e) == held[e], "R12 hold", get_p(e), held[e]);
        end
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(elem0_p == 0 && elem1_p == 0 && elem2_p == 0, "R1 products", longint'(elem0_p), 0);
        chk(!(elem0_vld | elem1_vld | elem2_vld), "R1 flags",
            longint'({elem2_vld, elem1_vld, elem0_vld}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(elem0_p == 0 && !elem0_vld, "R1 after release", longint'(elem0_p), 0);

        // Directed cases: every code with simple values.
        for (int c = 0; c < 8; c++) run_one(c, 3, -5, 7, 11, 4, -9);
        // Extreme half-difference: widest difference, must not overflow.
        run_one(1, -32768, 0, 0, 32767, -32768, 0);
        run_one(4, 0, 32767, 0, 0, -32768, 32767);
        // Odd products: floor rounding of the halving.
        run_one(1, 1, 0, 0, 1, 0, 0);
        run_one(1, -1, 0, 0, 1, 0, 0);
        run_one(3, -32768, 0, -32768, -32768, 0, -32768);
        run_one(5, -32768, 32767, -1, -32768, 32767, -32768);
        // Invalid code after a valid result clears every element.
        run_one(5, 100, 200, 300, 10, 20, 30);
        run_one(7, 100, 200, 300, 10, 20, 30);

        for (int k = 0; k < 300; k++) begin
            run_one(int'($urandom % 8),
                    int'(signed'(16'($urandom))), int'(signed'(16'($urandom))),
                    int'(signed'(16'($urandom))), int'(signed'(16'($urandom))),
                    int'(signed'(16'($urandom))), int'(signed'(16'($urandom))));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule